// File: doc/BRIEF.md
# Deferred-Commit Data Register Bank with Busy Timer

This block keeps the stored settings of a set of digitally controlled potentiometers: every pot owns a small group of six-bit data registers that behave as nonvolatile memory. The serial front end decodes host frames and presents each decoded command as a single-cycle strobe with an operation code, a pot select, a register select and, for host writes, a data word. The live wiper positions of all pots arrive on a flat bus so that a store command can copy them.

A write-type command does not change the bank when it arrives. It is parked in a staging register while chip select stays low. The bank is updated only when chip select goes high after a complete command was received, and only if the write-protect input is high. Each commit starts a busy window of a parameter-set number of clocks. During that window a write-in-progress flag is high, further write-type commands are dropped, and status reads still work. Reads return the value zero-extended on an eight-bit output one clock after the strobe.

Top module: `nvwc_ctrl`

## Requirements
- R1: After reset every data register holds zero, `wip` is 0 and `rd_data` is 0.
- R2: A host write (`cmd_op` = 1) of `wr_data` to register `reg_sel` of pot `pot_sel` leaves the bank unchanged until `cs_n` is seen rising, and the register holds the new value from the clock edge that sees that rise.
- R3: A single store (`cmd_op` = 2) copies the six bits of pot `pot_sel` from `wiper_vals` (pot k at bits 6k+5..6k), taken at the strobe, into register `reg_sel` of that pot only.
- R4: A global store (`cmd_op` = 3) copies every pot's slice of `wiper_vals`, taken at the strobe, into register `reg_sel` of every pot, all on the same clock edge.
- R5: A commit sets `wip` on the edge that sees `cs_n` rise, and `wip` stays high for exactly `BUSY_CYCLES` clocks.
- R6: A register read (`cmd_op` = 4) puts the addressed register, zero-extended, on `rd_data` on the edge that samples the strobe.
- R7: A status read (`cmd_op` = 5) puts `wip` in bit 0 of `rd_data` with all other bits 0, including while the busy window runs.
- R8: If `wp_n` is low when `cs_n` rises, no register changes and `wip` stays low.
- R9: A write-type command strobed while `wip` is high is dropped: no register changes and the busy window is not extended.
- R10: A chip-select window that holds no write-type strobe (an aborted sequence) changes no register and does not raise `wip`.
- R11: Strobes that arrive while `cs_n` is high are ignored: `rd_data` keeps its value and nothing is staged.
- R12: When several write-type strobes fall in one chip-select window, only the last one is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low; its rise commits staged writes |
| wp_n | input | 1 | Write protect, active low; low blocks commits |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Operation: 1 write, 2 store one, 3 store all, 4 read register, 5 read status |
| pot_sel | input | 2 | Pot addressed by the command |
| reg_sel | input | 2 | Register index within the pot |
| wr_data | input | 6 | Host write data |
| wiper_vals | input | 24 | Current wiper values, pot k at bits 6k+5..6k |
| rd_data | output | 8 | Read result, zero-extended |
| wip | output | 1 | Write in progress |

## Verification
A read strobe sampled on edge N shows on `rd_data` right after edge N; a commit happens on the edge that sees `cs_n` high after it was low, and the bank value and `wip` change right after that same edge, with `wip` dropping exactly `BUSY_CYCLES` edges later. The bench drives on the falling clock edge and compares against a behavioural model stepped on each rising edge, so every comparison at the falling edge lines up with those counts. Directed sequences then read values back through register reads and count the `wip` window cycle by cycle, including the protected, aborted, busy and unselected cases.

// File: rtl/nvwc_pkg.sv
package nvwc_pkg;

   typedef enum logic [2:0] {
      OP_NONE      = 3'd0,
      OP_WRITE_DR  = 3'd1,
      OP_STORE_ONE = 3'd2,
      OP_STORE_ALL = 3'd3,
      OP_READ_DR   = 3'd4,
      OP_READ_STAT = 3'd5
   } nvwc_op_e;

   function automatic logic is_write_op(input logic [2:0] op);
      return (op == OP_WRITE_DR) || (op == OP_STORE_ONE) || (op == OP_STORE_ALL);
   endfunction

endpackage

// File: rtl/nvwc_cs_edge.sv
module nvwc_cs_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   output logic cs_rise
);
   logic cs_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_n_q <= 1'b1;
      else        cs_n_q <= cs_n;
   end

   assign cs_rise = cs_n & ~cs_n_q;
endmodule

// File: rtl/nvwc_stage.sv
module nvwc_stage #(
   parameter int NUM_POTS = 4,
   parameter int DATA_W   = 6,
   parameter int POT_W    = 2,
   parameter int IDX_W    = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         accept,
   input  logic                         clear,
   input  logic [2:0]                   op,
   input  logic [POT_W-1:0]             pot_sel,
   input  logic [IDX_W-1:0]             reg_sel,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [NUM_POTS*DATA_W-1:0]   wiper_vals,
   output logic                         pend_valid,
   output logic [IDX_W-1:0]             pend_idx,
   output logic [NUM_POTS-1:0]          pend_mask,
   output logic [NUM_POTS*DATA_W-1:0]   pend_data
);
   import nvwc_pkg::*;

   localparam logic [NUM_POTS-1:0] ONE  = {{(NUM_POTS-1){1'b0}}, 1'b1};
   localparam logic [NUM_POTS-1:0] ALL  = {NUM_POTS{1'b1}};

   logic [NUM_POTS-1:0] sel_hot;
   logic [DATA_W-1:0]   sel_wiper;

   assign sel_hot   = ONE << pot_sel;
   assign sel_wiper = wiper_vals[pot_sel*DATA_W +: DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_idx   <= '0;
         pend_mask  <= '0;
         pend_data  <= '0;
      end else if (clear) begin
         pend_valid <= 1'b0;
         pend_mask  <= '0;
      end else if (accept) begin
         pend_valid <= 1'b1;
         pend_idx   <= reg_sel;
         unique case (op)
            OP_WRITE_DR: begin
               pend_mask <= sel_hot;
               pend_data[pot_sel*DATA_W +: DATA_W] <= wr_data;
            end
            OP_STORE_ONE: begin
               pend_mask <= sel_hot;
               pend_data[pot_sel*DATA_W +: DATA_W] <= sel_wiper;
            end
            OP_STORE_ALL: begin
               pend_mask <= ALL;
               pend_data <= wiper_vals;
            end
            default: begin
               pend_valid <= 1'b0;
               pend_mask  <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/nvwc_busy.sv
module nvwc_busy #(
   parameter int BUSY_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (start && !busy) begin
         busy   <= 1'b1;
         remain <= LOAD;
      end else if (busy) begin
         if (remain == '0) busy <= 1'b0;
         else              remain <= remain - 1'b1;
      end
   end
endmodule

// File: rtl/nvwc_bank.sv
module nvwc_bank #(
   parameter int                 NUM_POTS     = 4,
   parameter int                 REGS_PER_POT = 4,
   parameter int                 DATA_W       = 6,
   parameter int                 POT_W        = 2,
   parameter int                 IDX_W        = 2,
   parameter logic [DATA_W-1:0]  INIT_VAL     = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        commit,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [NUM_POTS-1:0]         wr_mask,
   input  logic [NUM_POTS*DATA_W-1:0]  wr_data,
   input  logic [POT_W-1:0]            rd_pot,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic [DATA_W-1:0]           rd_val
);
   logic [NUM_POTS*DATA_W-1:0] pot_out;

   for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
      logic [DATA_W-1:0] cells [REGS_PER_POT];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < REGS_PER_POT; i++) cells[i] <= INIT_VAL;
         end else if (commit && wr_mask[p]) begin
            cells[wr_idx] <= wr_data[p*DATA_W +: DATA_W];
         end
      end

      assign pot_out[p*DATA_W +: DATA_W] = cells[rd_idx];
   end

   assign rd_val = pot_out[rd_pot*DATA_W +: DATA_W];
endmodule

// File: rtl/nvwc_ctrl.sv
module nvwc_ctrl #(
   parameter int NUM_POTS     = 4,
   parameter int REGS_PER_POT = 4,
   parameter int DATA_W       = 6,
   parameter int RD_W         = 8,
   parameter int BUSY_CYCLES  = 40,
   parameter int POT_W        = $clog2(NUM_POTS),
   parameter int IDX_W        = $clog2(REGS_PER_POT)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cs_n,
   input  logic                        wp_n,
   input  logic                        cmd_valid,
   input  logic [2:0]                  cmd_op,
   input  logic [POT_W-1:0]            pot_sel,
   input  logic [IDX_W-1:0]            reg_sel,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic [NUM_POTS*DATA_W-1:0]  wiper_vals,
   output logic [RD_W-1:0]             rd_data,
   output logic                        wip
);
   import nvwc_pkg::*;

   if (NUM_POTS < 2 || (1 << POT_W) != NUM_POTS) begin : g_bad_pots
      $error("NUM_POTS must be a power of two of at least 2");
   end
   if (REGS_PER_POT < 2 || (1 << IDX_W) != REGS_PER_POT) begin : g_bad_regs
      $error("REGS_PER_POT must be a power of two of at least 2");
   end
   if (RD_W < DATA_W) begin : g_bad_rd
      $error("RD_W must be at least DATA_W");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end

   logic                       cs_rise;
   logic                       accept;
   logic                       accept_wr;
   logic                       commit;
   logic                       pend_valid;
   logic [IDX_W-1:0]           pend_idx;
   logic [NUM_POTS-1:0]        pend_mask;
   logic [NUM_POTS*DATA_W-1:0] pend_data;
   logic [DATA_W-1:0]          bank_rd;

   assign accept    = cmd_valid & ~cs_n;
   assign accept_wr = accept & is_write_op(cmd_op) & ~wip;
   assign commit    = cs_rise & pend_valid & wp_n & ~wip;

   nvwc_cs_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .cs_rise (cs_rise)
   );

   nvwc_stage #(
      .NUM_POTS (NUM_POTS),
      .DATA_W   (DATA_W),
      .POT_W    (POT_W),
      .IDX_W    (IDX_W)
   ) u_stage (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept_wr),
      .clear      (cs_rise),
      .op         (cmd_op),
      .pot_sel    (pot_sel),
      .reg_sel    (reg_sel),
      .wr_data    (wr_data),
      .wiper_vals (wiper_vals),
      .pend_valid (pend_valid),
      .pend_idx   (pend_idx),
      .pend_mask  (pend_mask),
      .pend_data  (pend_data)
   );

   nvwc_bank #(
      .NUM_POTS     (NUM_POTS),
      .REGS_PER_POT (REGS_PER_POT),
      .DATA_W       (DATA_W),
      .POT_W        (POT_W),
      .IDX_W        (IDX_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (commit),
      .wr_idx  (pend_idx),
      .wr_mask (pend_mask),
      .wr_data (pend_data),
      .rd_pot  (pot_sel),
      .rd_idx  (reg_sel),
      .rd_val  (bank_rd)
   );

   nvwc_busy #(
      .BUSY_CYCLES (BUSY_CYCLES)
   ) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (commit),
      .busy  (wip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (accept) begin
         if (cmd_op == OP_READ_DR)   rd_data <= RD_W'(bank_rd);
         if (cmd_op == OP_READ_STAT) rd_data <= RD_W'(wip);
      end
   end
endmodule

// File: rtl/nvwc_ctrl_chk.sv
module nvwc_ctrl_chk #(
   parameter int RD_W        = 8,
   parameter int BUSY_CYCLES = 40
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cs_n,
   input logic            wp_n,
   input logic            cmd_valid,
   input logic [2:0]      cmd_op,
   input logic [RD_W-1:0] rd_data,
   input logic            wip
);
   int busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   busy_len <= 0;
      else if (wip) busy_len <= busy_len + 1;
      else          busy_len <= 0;
   end

   assert_wip_on_cs_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> ($past(cs_n) && !$past(cs_n, 2)));

   assert_wip_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> (busy_len == BUSY_CYCLES));

   assert_wip_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_len <= BUSY_CYCLES);

   assert_protect_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> $past(wp_n));

   assert_status_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_valid && !cs_n && cmd_op == 3'd5) |-> (rd_data == RD_W'($past(wip))));

   assert_unselected_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> $stable(rd_data));
endmodule

bind nvwc_ctrl nvwc_ctrl_chk #(
   .RD_W        (RD_W),
   .BUSY_CYCLES (BUSY_CYCLES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .wp_n      (wp_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .rd_data   (rd_data),
   .wip       (wip)
);

// File: tb/nvwc_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvwc_ctrl_tb_top;
   localparam int B = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        wp_n = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [1:0]  pot_sel = 2'd0;
   logic [1:0]  reg_sel = 2'd0;
   logic [5:0]  wr_data = 6'd0;
   logic [23:0] wiper_vals = 24'd0;
   logic [7:0]  rd_data;
   logic        wip;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   nvwc_ctrl #(.BUSY_CYCLES(B)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .pot_sel(pot_sel),
      .reg_sel(reg_sel), .wr_data(wr_data), .wiper_vals(wiper_vals),
      .rd_data(rd_data), .wip(wip)
   );

   // behavioural reference model
   int m_dr [16];
   int m_pdata [4];
   int m_pmask [4];
   int m_pidx, m_cnt, m_rd;
   bit m_pend, m_wip, m_csq;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_dr[i]) m_dr[i] = 0;
         m_pend = 0; m_wip = 0; m_csq = 1; m_rd = 0; m_cnt = 0;
      end else begin
         bit was_busy;
         bit rise;
         was_busy = m_wip;
         rise = cs_n && !m_csq;
         if (cmd_valid && !cs_n) begin
            if (cmd_op == 3'd4) m_rd = m_dr[pot_sel*4 + reg_sel];
            if (cmd_op == 3'd5) m_rd = m_wip ? 1 : 0;
         end
         if (m_wip) begin
            if (m_cnt == 0) m_wip = 0;
            else m_cnt = m_cnt - 1;
         end else if (rise && m_pend && wp_n) begin
            for (int p = 0; p < 4; p++)
               if (m_pmask[p] != 0) m_dr[p*4 + m_pidx] = m_pdata[p];
            m_wip = 1;
            m_cnt = B - 1;
         end
         if (rise) m_pend = 0;
         else if (cmd_valid && !cs_n && !was_busy && cmd_op >= 3'd1 && cmd_op <= 3'd3) begin
            m_pend = 1;
            m_pidx = reg_sel;
            for (int p = 0; p < 4; p++) m_pmask[p] = 0;
            if (cmd_op == 3'd3) begin
               for (int p = 0; p < 4; p++) begin
                  m_pmask[p] = 1;
                  m_pdata[p] = wiper_vals[p*6 +: 6];
               end
            end else begin
               m_pmask[pot_sel] = 1;
               m_pdata[pot_sel] = (cmd_op == 3'd1) ? wr_data : wiper_vals[pot_sel*6 +: 6];
            end
         end
         m_csq = cs_n;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R5 model wip", wip, m_wip);
         check("R6 model rd_data", rd_data, m_rd);
      end
   end

   task automatic tick(); @(negedge clk); endtask

   task automatic strobe(input int op, input int p, input int r, input int d);
      cmd_valid = 1; cmd_op = 3'(op); pot_sel = 2'(p); reg_sel = 2'(r); wr_data = 6'(d);
      tick();
      cmd_valid = 0;
   endtask

   task automatic read_reg(input int p, input int r, output int v);
      cs_n = 0; tick();
      strobe(4, p, r, 0);
      v = rd_data;
      cs_n = 1; tick();
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && wip; i++) tick();
   endtask

   initial begin
      int v;
      repeat (3) tick();
      check("R1 wip after reset", wip, 0);
      check("R1 rd_data after reset", rd_data, 0);
      rst_n = 1; tick();
      read_reg(3, 3, v); check("R1 register zero", v, 0);

      // R2 deferred write, R5 window length
      cs_n = 0; tick();
      strobe(1, 1, 2, 6'h2A);
      strobe(4, 1, 2, 0);
      check("R2 not visible before cs rise", rd_data, 0);
      cs_n = 1; tick();
      check("R5 wip set at commit", wip, 1);
      repeat (B - 1) tick();
      check("R5 wip still high at last busy cycle", wip, 1);
      tick();
      check("R5 wip low after window", wip, 0);
      read_reg(1, 2, v); check("R2 committed value", v, 6'h2A);
      check("R6 read zero extended", rd_data, 8'h2A);

      // R7 status while busy, R9 writes dropped while busy
      cs_n = 0; tick(); strobe(1, 0, 0, 6'h15); cs_n = 1; tick();
      cs_n = 0; tick();
      strobe(5, 0, 0, 0);
      check("R7 status busy", rd_data, 1);
      strobe(1, 2, 1, 6'h3F);
      cs_n = 1; tick();
      wait_idle();
      cs_n = 0; tick(); strobe(5, 0, 0, 0);
      check("R7 status idle", rd_data, 0);
      cs_n = 1; tick();
      read_reg(2, 1, v); check("R9 busy write dropped", v, 0);
      read_reg(0, 0, v); check("R2 second write", v, 6'h15);

      // R3 single store
      wiper_vals = {6'h31, 6'h22, 6'h13, 6'h04};
      cs_n = 0; tick(); strobe(2, 2, 3, 0); cs_n = 1; tick();
      wait_idle();
      read_reg(2, 3, v); check("R3 store one target", v, 6'h22);
      read_reg(0, 3, v); check("R3 other pot untouched", v, 0);

      // R4 global store, wiper sampled at strobe
      wiper_vals = {6'h3E, 6'h2D, 6'h1C, 6'h0B};
      cs_n = 0; tick(); strobe(3, 0, 1, 0);
      wiper_vals = 24'hFFFFFF; tick();
      cs_n = 1; tick();
      wait_idle();
      read_reg(0, 1, v); check("R4 pot0", v, 6'h0B);
      read_reg(1, 1, v); check("R4 pot1", v, 6'h1C);
      read_reg(2, 1, v); check("R4 pot2", v, 6'h2D);
      read_reg(3, 1, v); check("R4 pot3", v, 6'h3E);

      // R8 write protect
      wp_n = 0;
      cs_n = 0; tick(); strobe(1, 3, 0, 6'h11); cs_n = 1; tick();
      check("R8 no busy when protected", wip, 0);
      wp_n = 1; tick();
      read_reg(3, 0, v); check("R8 register unchanged", v, 0);

      // R10 aborted window
      cs_n = 0; repeat (3) tick(); cs_n = 1; tick();
      check("R10 no busy after empty window", wip, 0);

      // R11 strobes while deselected
      read_reg(1, 2, v);
      strobe(4, 0, 1, 0);
      check("R11 read ignored while deselected", rd_data, 8'h2A);
      strobe(1, 0, 1, 6'h01);
      cs_n = 0; tick(); cs_n = 1; tick();
      check("R11 no commit from deselected strobe", wip, 0);
      read_reg(0, 1, v); check("R11 register unchanged", v, 6'h0B);

      // R12 last write wins
      cs_n = 0; tick();
      strobe(1, 1, 3, 6'h09);
      strobe(1, 0, 2, 6'h07);
      cs_n = 1; tick();
      wait_idle();
      read_reg(1, 3, v); check("R12 earlier strobe discarded", v, 0);
      read_reg(0, 2, v); check("R12 last strobe committed", v, 6'h07);

      repeat (3) tick();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule